// File: doc/BRIEF.md
# I2C Register-Map Target

This block is an I2C target that lets a bus host read and write a bank of 8-bit control registers held outside the block. Access goes through an internal 7-bit pointer. In a write transfer, the host sends the device address and then a pointer byte. The top bit of the pointer byte turns on auto-advance, and the low seven bits select a register. Any further bytes in the same transfer are stored to registers through a simple register-file port.

A read transfer cannot change the pointer. It streams out register contents starting at the pointer's current value. To read from a chosen register, the host first sends a write that it cuts short with STOP right after the pointer byte. It then issues a read, either after the STOP or through a repeated START.

SCL and SDA are seen as sampled input levels, with one pull-low enable for SDA. Both lines are oversampled on the system clock. The register file is expected to return read data combinationally for the address the block presents.

Top module: `regport_i2c_target`

## Requirements
- R1: The block answers only to the 7-bit address formed by the bits 100101 followed by the level of `addr_sel` as the least significant bit. Address byte bit 0 selects the direction: 0 means write, 1 means read.
- R2: After each byte the block accepts (address, pointer or data), it pulls SDA low for the whole ninth SCL clock.
- R3: In a write transfer, the byte after the address loads the pointer. Bit 7 of that byte sets the auto-advance mode and bits 6..0 set the register index.
- R4: Each later byte of the write transfer is shifted in MSB first. It is then presented on `reg_wdata`, with `reg_addr` equal to the pointer, during a `reg_we` pulse that lasts exactly one clock cycle.
- R5: With auto-advance on, the pointer steps by one after every data byte written or read, and it wraps from 0x7F to 0x00.
- R6: With auto-advance off, the pointer stays fixed, so repeated writes or reads all hit one register.
- R7: A read transfer returns the register that the pointer selects, MSB first, and never loads the pointer.
- R8: A STOP that follows the acknowledged pointer byte ends the write without any register write, and the pointer value is kept.
- R9: When the host answers a read byte with NO-ACK, the block releases SDA and drives nothing more until the next START.
- R10: A mismatched address gets no acknowledge. The rest of that transfer causes no register write and no SDA drive.
- R11: A START seen at any point, including a repeated START in the middle of a byte, restarts reception with a fresh address byte.
- R12: After reset, the pointer is 0x00 with auto-advance off, SDA is released and `reg_we` is low.
- R13: The block only begins pulling SDA low while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, fast enough to oversample SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 1 | Least significant bit of the device address |
| reg_addr | output | 7 | Register index (the current pointer) |
| reg_wdata | output | 8 | Byte to be stored |
| reg_we | output | 1 | Single-cycle store strobe |
| reg_rdata | input | 8 | Contents of register `reg_addr` |

## Verification
The bench builds the block with its defaults: a two-stage input synchronizer, the 100101 address prefix and `addr_sel` tied high. With eight system clocks per quarter SCL bit, the synchronizer latency stays well inside each SCL phase, so every SDA change by the host or the target falls safely between SCL edges. The 7-bit pointer lets a single pointer byte of 0xFF reach the 0x7F-to-0x00 wrap. Flipping the address-select bit in the host's address byte is enough to produce a mismatch.

// File: rtl/regport_pkg.sv
`timescale 1ns/1ps
// Shared types for the I2C register-map target.
// Assumes: byte-oriented I2C framing, 7-bit addressing only.
package regport_pkg;
    // Bus phase of the target's byte engine
    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer addressed to us
        ST_RECV,   // shifting a byte in on SCL rising edges
        ST_HOLD,   // byte complete, waiting for SCL to fall
        ST_ACKO,   // driving our acknowledge bit
        ST_SEND,   // shifting a byte out
        ST_ACKI,   // sampling the host's acknowledge
        ST_SKIP    // ignoring the bus until the next START
    } phase_t;

    // Meaning of the byte currently being received
    typedef enum logic [1:0] {
        K_ADDR,
        K_PTR,
        K_DATA
    } kind_t;
endpackage

// File: rtl/i2c_line_sampler.sv
`timescale 1ns/1ps
// Brings SCL and SDA into the clock domain and derives bus events.
// Assumes: both lines pass through equal-depth synchronizers, so their
// relative order is kept; SYNC_STAGES >= 2.
module i2c_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic [SYNC_STAGES-1:0] scl_pipe;
    logic [SYNC_STAGES-1:0] sda_pipe;
    logic                   scl_q;
    logic                   sda_q;

    // Synchronizer chains plus one delayed copy for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
            scl_q    <= scl_pipe[SYNC_STAGES-1];
            sda_q    <= sda_pipe[SYNC_STAGES-1];
        end
    end

    // Level and event decode
    always_comb begin
        scl_lvl  = scl_pipe[SYNC_STAGES-1];
        sda_lvl  = sda_pipe[SYNC_STAGES-1];
        scl_rise = scl_lvl & ~scl_q;
        scl_fall = ~scl_lvl & scl_q;
        start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
        stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
    end
endmodule

// File: rtl/i2c_pointer.sv
`timescale 1ns/1ps
// Register pointer with optional auto-advance.
// Assumes: load and step never coincide; step is a one-cycle pulse.
module i2c_pointer #(
    parameter int PTR_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             load_inc,
    input  logic [PTR_W-1:0] load_addr,
    input  logic             step,
    output logic [PTR_W-1:0] ptr,
    output logic             inc_en
);
    localparam logic [PTR_W-1:0] PTR_TOP = '1;

    // Pointer update: load from pointer byte, else advance if enabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr    <= '0;
            inc_en <= 1'b0;
        end else if (load) begin
            ptr    <= load_addr;
            inc_en <= load_inc;
        end else if (step && inc_en) begin
            ptr <= ptr + PTR_W'(1);
        end
    end

    // R5: advancing from the top index wraps to zero
    a_r5_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (step && inc_en && !load && ptr == PTR_TOP) |=> (ptr == '0));

    // R6: with auto-advance off a step leaves the pointer alone
    a_r6_ptr_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !inc_en && !load) |=> $stable(ptr));
endmodule

// File: rtl/regport_i2c_target.sv
`timescale 1ns/1ps
// I2C target giving pointer-based access to an external 8-bit register bank.
// Assumes: clk oversamples SCL by a wide margin; reg_rdata is a
// combinational function of reg_addr; no clock stretching.
module regport_i2c_target
    import regport_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [5:0] DEV_PREFIX  = 6'b100101
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    output logic [6:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    input  logic [7:0] reg_rdata
);
    localparam int BYTE_W = 8;
    localparam int PTR_W  = BYTE_W - 1;
    localparam int CNT_W  = $clog2(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    phase_t             st;
    kind_t              kind;
    logic [BYTE_W-1:0]  sh;
    logic [CNT_W-1:0]   cnt;
    logic               rw, oe, we, tx_step, acked;
    logic               ptr_load;
    logic [PTR_W-1:0]   ptr;
    logic               inc_en;

    i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_lines (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    // Pointer byte is taken when its acknowledge phase begins
    assign ptr_load = (st == ST_HOLD) && scl_fall && (kind == K_PTR);

    i2c_pointer #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_inc(sh[BYTE_W-1]),
        .load_addr(sh[PTR_W-1:0]), .step(we | tx_step),
        .ptr(ptr), .inc_en(inc_en)
    );

    // Bit/byte engine: receive, acknowledge, transmit, host-ack sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            kind    <= K_ADDR;
            sh      <= '0;
            cnt     <= '0;
            rw      <= 1'b0;
            oe      <= 1'b0;
            we      <= 1'b0;
            tx_step <= 1'b0;
            acked   <= 1'b0;
        end else begin
            we      <= 1'b0;
            tx_step <= 1'b0;
            if (start_ev) begin
                st    <= ST_RECV;
                kind  <= K_ADDR;
                cnt   <= '0;
                oe    <= 1'b0;
                acked <= 1'b0;
            end else if (stop_ev) begin
                st <= ST_IDLE;
                oe <= 1'b0;
            end else begin
                case (st)
                    ST_RECV: if (scl_rise) begin
                        sh  <= {sh[BYTE_W-2:0], sda_lvl};
                        cnt <= cnt + CNT_W'(1);
                        if (cnt == LAST_BIT) st <= ST_HOLD;
                    end
                    ST_HOLD: if (scl_fall) begin
                        case (kind)
                            K_ADDR: if (sh[BYTE_W-1:1] == {DEV_PREFIX, addr_sel}) begin
                                rw <= sh[0];
                                oe <= 1'b1;
                                st <= ST_ACKO;
                            end else begin
                                st <= ST_SKIP;
                            end
                            K_PTR: begin
                                oe <= 1'b1;
                                st <= ST_ACKO;
                            end
                            default: begin
                                we <= 1'b1;
                                oe <= 1'b1;
                                st <= ST_ACKO;
                            end
                        endcase
                    end
                    ST_ACKO: if (scl_fall) begin
                        cnt <= '0;
                        if (kind == K_ADDR && rw) begin
                            sh <= reg_rdata;
                            oe <= ~reg_rdata[BYTE_W-1];
                            st <= ST_SEND;
                        end else begin
                            oe   <= 1'b0;
                            st   <= ST_RECV;
                            kind <= (kind == K_ADDR) ? K_PTR : K_DATA;
                        end
                    end
                    ST_SEND: if (scl_fall) begin
                        if (cnt == LAST_BIT) begin
                            oe      <= 1'b0;
                            tx_step <= 1'b1;
                            acked   <= 1'b0;
                            st      <= ST_ACKI;
                        end else begin
                            sh  <= {sh[BYTE_W-2:0], 1'b0};
                            oe  <= ~sh[BYTE_W-2];
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    ST_ACKI: if (scl_rise) begin
                        if (sda_lvl) st <= ST_SKIP;
                        else         acked <= 1'b1;
                    end else if (scl_fall && acked) begin
                        sh  <= reg_rdata;
                        oe  <= ~reg_rdata[BYTE_W-1];
                        cnt <= '0;
                        st  <= ST_SEND;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe    = oe;
    assign reg_we    = we;
    assign reg_wdata = sh;
    assign reg_addr  = ptr;

    // R4: the store strobe lasts a single cycle
    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R13: SDA pull-down only starts while SCL was low
    a_r13_oe_rise_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_lvl));

    // R2: during our acknowledge phase SDA is pulled low
    a_r2_ack_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ACKO) |-> sda_oe);

    // R9 / R10: an ignoring target never drives SDA
    a_r10_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SKIP) |-> !sda_oe);

    // R11: any START returns the engine to address reception
    a_r11_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (st == ST_RECV && kind == K_ADDR && !sda_oe));
endmodule

// File: tb/sim_regport_i2c_target.sv
`timescale 1ns/1ps
module sim_regport_i2c_target;
    localparam int Q = 8;              // system clocks per quarter SCL bit
    localparam logic SEL = 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic h_scl = 1'b1, h_sda = 1'b1;
    logic sda_oe, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    wire  sda_line = h_sda & ~sda_oe;

    always #2.5 clk = ~clk;            // 200 MHz

    regport_i2c_target u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(h_scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .addr_sel(SEL), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    // Register bank on the block's register-file port
    logic [7:0] mem [128];
    assign reg_rdata = mem[reg_addr];
    always @(posedge clk) if (reg_we) mem[reg_addr] <= reg_wdata;

    // Behavioural reference model
    logic [7:0] exp_mem [128];
    int         m_ptr = 0;
    bit         m_inc = 1'b0;
    logic [14:0] wq[$];
    int n_chk = 0, n_fail = 0;
    bit prev_oe = 1'b0;

    initial for (int i = 0; i < 128; i++) begin
        mem[i]     = 8'((i * 37 + 11) & 255);
        exp_mem[i] = 8'((i * 37 + 11) & 255);
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Per-clock comparison of stores and SDA drive timing against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (wq.size() == 0) check(1'b0, "R4/R10 unexpected store", {reg_addr, reg_wdata}, 0);
                else begin
                    logic [14:0] e;
                    e = wq.pop_front();
                    check({reg_addr, reg_wdata} == e, "R4 store addr/data", {reg_addr, reg_wdata}, e);
                end
            end
            if (sda_oe && !prev_oe) check(!h_scl, "R13 drive start with SCL low", h_scl, 0);
            prev_oe = sda_oe;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_start;
        h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q);
        h_sda = 1'b0; tick(Q); h_scl = 1'b0; tick(Q);
    endtask

    task automatic host_stop;
        h_sda = 1'b0; tick(Q); h_scl = 1'b1; tick(Q); h_sda = 1'b1; tick(Q);
    endtask

    task automatic put_bit(input bit b);
        h_sda = b; tick(Q); h_scl = 1'b1; tick(2 * Q); h_scl = 1'b0; tick(Q);
    endtask

    task automatic get_bit(output bit b);
        h_sda = 1'b1; tick(Q); h_scl = 1'b1; tick(Q);
        b = sda_line; tick(Q); h_scl = 1'b0; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic recv_byte(output logic [7:0] v, input bit host_ack);
        bit b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(!host_ack);
    endtask

    function automatic logic [7:0] abyte(input bit sel, input bit rd);
        return {6'b100101, sel, rd};
    endfunction

    // Write transfer: pointer byte then n data bytes seed, seed+0x11, ...
    task automatic wr_xfer(input logic [7:0] pb, input int n, input logic [7:0] seed, input bit stop_it);
        bit ack;
        host_start;
        send_byte(abyte(SEL, 1'b0), ack);
        check(ack, "R1/R2 address ack (write)", ack, 1);
        send_byte(pb, ack);
        check(ack, "R2/R3 pointer ack", ack, 1);
        m_ptr = pb[6:0];
        m_inc = pb[7];
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = seed + 8'(k * 17);
            wq.push_back({7'(m_ptr), d});
            exp_mem[m_ptr] = d;
            send_byte(d, ack);
            check(ack, "R2/R4 data ack", ack, 1);
            if (m_inc) m_ptr = (m_ptr + 1) % 128;
        end
        if (stop_it) host_stop;
    endtask

    // Read transfer of n bytes, last one answered with NO-ACK
    task automatic rd_xfer(input int n, input string req);
        bit ack;
        logic [7:0] v;
        host_start;
        send_byte(abyte(SEL, 1'b1), ack);
        check(ack, "R1/R2 address ack (read)", ack, 1);
        for (int k = 0; k < n; k++) begin
            recv_byte(v, k != n - 1);
            check(v == exp_mem[m_ptr], req, v, exp_mem[m_ptr]);
            if (m_inc) m_ptr = (m_ptr + 1) % 128;
        end
        tick(2);
        check(!sda_oe, "R9 released after NO-ACK", sda_oe, 0);
        host_stop;
    endtask

    initial begin
        bit ack;
        logic [7:0] v;
        tick(4);
        rst_n = 1'b1;
        tick(2);
        check(!sda_oe, "R12 SDA released after reset", sda_oe, 0);
        check(!reg_we, "R12 no strobe after reset", reg_we, 0);
        tick(Q);

        // R12: pointer 0x00, auto-advance off -> same register twice
        rd_xfer(2, "R12/R7 reset pointer read");

        // R3 R4 R5: auto-advance burst write
        wr_xfer(8'h90, 3, 8'hA1, 1'b1);
        // R8: aborted write keeps pointer, no store; R6 fixed read
        wr_xfer(8'h11, 0, 8'h00, 1'b1);
        rd_xfer(2, "R8/R6 read after aborted write");
        // R5 R7: auto-advance burst read
        wr_xfer(8'h90, 0, 8'h00, 1'b1);
        rd_xfer(3, "R5/R7 burst read");

        // R5: wrap 0x7F -> 0x00 on write and read
        wr_xfer(8'hFF, 2, 8'h5A, 1'b1);
        wr_xfer(8'hFF, 0, 8'h00, 1'b1);
        rd_xfer(2, "R5 wrap read");

        // R6: fixed pointer write hits one register
        wr_xfer(8'h05, 2, 8'h33, 1'b1);
        rd_xfer(1, "R6 fixed write result");

        // R10: wrong address -> no ack, no store, pointer untouched
        host_start;
        send_byte(abyte(!SEL, 1'b0), ack);
        check(!ack, "R10 no ack for other address", ack, 0);
        send_byte(8'h80, ack);
        check(!ack, "R10 no ack for later byte", ack, 0);
        send_byte(8'hEE, ack);
        check(!ack, "R10 no ack for data", ack, 0);
        host_stop;
        rd_xfer(1, "R10 pointer unchanged");

        // R9: after NO-ACK, further clocks read released SDA
        host_start;
        send_byte(abyte(SEL, 1'b1), ack);
        check(ack, "R1 read address ack", ack, 1);
        recv_byte(v, 1'b0);
        check(v == exp_mem[m_ptr], "R7 single read", v, exp_mem[m_ptr]);
        for (int i = 0; i < 8; i++) begin
            bit b;
            get_bit(b);
            check(b, "R9 bus ignored after NO-ACK", b, 1);
        end
        host_stop;

        // R11: repeated START between pointer write and read
        wr_xfer(8'hA0, 0, 8'h00, 1'b0);
        rd_xfer(2, "R11 repeated START read");

        // R11: START in the middle of a byte restarts reception
        host_start;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        wr_xfer(8'hB0, 2, 8'hC4, 1'b1);
        wr_xfer(8'hB0, 0, 8'h00, 1'b1);
        rd_xfer(2, "R11 write after mid-byte START");

        tick(4);
        check(wq.size() == 0, "R4 all expected stores seen", wq.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule